// File: doc/BRIEF.md
# Window Alarm Flag Unit

This block watches a stream of 16-bit conversion results, each tagged with a channel number and a valid strobe. It compares every result against a programmable lower and upper limit for that channel. For each limit it keeps two status bits. A live bit shows whether the most recent sample for the channel is outside that limit. A latched bit records that the limit was crossed at some point, and it stays set until software reads the register that holds it. The limits and the flag bytes share one byte-wide register port. A serial front end would normally drive that port.

The flag bits live in four read-only bytes. Two bytes hold latched flags and two hold live flags, and each byte covers four channels. Inside a byte, every channel takes a pair of adjacent bits, with the low-limit bit above the high-limit bit. The `NUM_CH` parameter sets the build to 8 or 4 channels. In the 4-channel build the upper channels do not exist and their flag bytes read back as all ones.

Top module: `win_alarm_flags`

## Requirements
- R1: After reset every flag bit reads 0. Every channel's low limit reads 16'h0000 and its high limit reads 16'hFFFF, so no sample can raise an alarm.
- R2: A valid sample for channel c sets the live low flag of c to (sample < low limit) and the live high flag of c to (sample > high limit). Both comparisons are strict and unsigned. A live flag changes only when a valid sample arrives for its own channel.
- R3: A latched flag sets on the same condition as its live flag. It stays set after the condition goes away, until its byte is read.
- R4: A read of a latched-flag byte returns the bits as they were before the read, and then clears them. A read of a live-flag byte clears nothing.
- R5: When a new alarm event and a clearing read of the same latched byte fall in the same cycle, the bit is left set.
- R6: The flag bytes sit at fixed addresses: 8'h11 holds latched flags for channels 0-3, 8'h12 holds live flags for channels 0-3, 8'h13 holds latched flags for channels 4-7, and 8'h14 holds live flags for channels 4-7. Local channel k (0..3) of a byte uses bit 7-2k for its low flag and bit 6-2k for its high flag. A bit value of 1 means an alarm.
- R7: The limits of channel c are read/write bytes at 8'h20+4c: +0 is low[7:0], +1 is low[15:8], +2 is high[7:0] and +3 is high[15:8]. Any other address reads 8'h00.
- R8: Writes to 8'h11..8'h14 change no flag.
- R9: With NUM_CH=4, the bytes at 8'h13 and 8'h14 read 8'hFF. Samples tagged with channels 4-7 are ignored. The limit addresses of channels 4-7 read 8'h00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_chan | input | 3 | Channel number of the sample |
| smp_data | input | 16 | Unsigned sample value |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; clears latched bytes it reads |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |

## Verification
The bench builds the block twice, once with NUM_CH=8 and once with NUM_CH=4. The 8-channel instance covers the full map. It checks the bit position of each flag in all four bytes, strict comparison at exactly-equal samples, and the read that collides with a new event. The 4-channel instance covers the all-ones upper bytes, the dropped samples and the absent limit registers. These can only be seen when the parameter removes channels.

// File: rtl/win_alarm_flags.sv
module win_alarm_flags #(
  parameter int NUM_CH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [2:0]  smp_chan,
  input  logic [15:0] smp_data,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_rd,
  output logic [7:0]  reg_rdata
);
  localparam bit FULL = NUM_CH > 4;

  logic [15:0] thr_lo [NUM_CH];
  logic [15:0] thr_hi [NUM_CH];
  logic [NUM_CH-1:0] act_lo, act_hi, trp_lo, trp_hi;
  logic [NUM_CH-1:0] hit, lo_ev, hi_ev, clr;
  logic [7:0] act_b0, act_b1, trp_b0, trp_b1;

  function automatic logic [7:0] pack(input logic [7:0] lo, input logic [7:0] hi, input int g);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      b[7-2*k] = lo[4*g+k];
      b[6-2*k] = hi[4*g+k];
    end
    return b;
  endfunction

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      hit[c]   = smp_valid && smp_chan == 3'(c);
      lo_ev[c] = hit[c] && smp_data < thr_lo[c];
      hi_ev[c] = hit[c] && smp_data > thr_hi[c];
      clr[c]   = reg_rd && reg_addr == 8'(17 + 2 * (c / 4));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_lo <= '0;
      act_hi <= '0;
      trp_lo <= '0;
      trp_hi <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        thr_lo[c] <= 16'h0000;
        thr_hi[c] <= 16'hFFFF;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (hit[c]) begin
          act_lo[c] <= lo_ev[c];
          act_hi[c] <= hi_ev[c];
        end
        trp_lo[c] <= (trp_lo[c] & ~clr[c]) | lo_ev[c];
        trp_hi[c] <= (trp_hi[c] & ~clr[c]) | hi_ev[c];
        if (reg_wr && reg_addr[7:2] == 6'(8 + c)) begin
          case (reg_addr[1:0])
            2'd0: thr_lo[c][7:0]  <= reg_wdata;
            2'd1: thr_lo[c][15:8] <= reg_wdata;
            2'd2: thr_hi[c][7:0]  <= reg_wdata;
            default: thr_hi[c][15:8] <= reg_wdata;
          endcase
        end
      end
    end
  end

  assign act_b0 = pack(8'(act_lo), 8'(act_hi), 0);
  assign act_b1 = pack(8'(act_lo), 8'(act_hi), 1);
  assign trp_b0 = pack(8'(trp_lo), 8'(trp_hi), 0);
  assign trp_b1 = pack(8'(trp_lo), 8'(trp_hi), 1);

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      8'h11: reg_rdata = trp_b0;
      8'h12: reg_rdata = act_b0;
      8'h13: reg_rdata = FULL ? trp_b1 : 8'hFF;
      8'h14: reg_rdata = FULL ? act_b1 : 8'hFF;
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (reg_addr[7:2] == 6'(8 + c)) begin
            case (reg_addr[1:0])
              2'd0: reg_rdata = thr_lo[c][7:0];
              2'd1: reg_rdata = thr_lo[c][15:8];
              2'd2: reg_rdata = thr_hi[c][7:0];
              default: reg_rdata = thr_hi[c][15:8];
            endcase
          end
        end
      end
    endcase
  end

  a_r2_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(act_b0) && $stable(act_b1)));

  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == 8'h11) |=> ((trp_b0 & $past(trp_b0)) == $past(trp_b0)));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'h11 && !smp_valid) |=> (trp_b0 == 8'h00));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'h11 && smp_valid && smp_chan == 3'd0 && smp_data > thr_hi[0])
    |=> trp_b0[6]);

  a_r9_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!FULL && (reg_addr == 8'h13 || reg_addr == 8'h14)) |-> (reg_rdata == 8'hFF));
endmodule

// File: tb/sim_win_alarm_flags.sv
module sim_win_alarm_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic v0 = 0, wr0 = 0, rd0 = 0, v1 = 0, wr1 = 0, rd1 = 0;
  logic [2:0]  ch0 = 0, ch1 = 0;
  logic [15:0] d0 = 0, d1 = 0;
  logic [7:0]  a0 = 0, wd0 = 0, a1 = 0, wd1 = 0;
  logic [7:0]  q0_rd, q1_rd;

  win_alarm_flags #(.NUM_CH(8)) u0 (.clk(clk), .rst_n(rst_n), .smp_valid(v0), .smp_chan(ch0),
    .smp_data(d0), .reg_addr(a0), .reg_wr(wr0), .reg_wdata(wd0), .reg_rd(rd0), .reg_rdata(q0_rd));
  win_alarm_flags #(.NUM_CH(4)) u1 (.clk(clk), .rst_n(rst_n), .smp_valid(v1), .smp_chan(ch1),
    .smp_data(d1), .reg_addr(a1), .reg_wr(wr1), .reg_wdata(wd1), .reg_rd(rd1), .reg_rdata(q1_rd));

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp0[$], exp1[$];
  string tag0[$], tag1[$];

  always @(negedge clk) begin
    #2;
    if (rd0) begin
      logic [7:0] e; string t;
      e = exp0.pop_front(); t = tag0.pop_front();
      total++;
      if (q0_rd !== e) begin bad++; $display("FAIL %s u0: got %02h exp %02h", t, q0_rd, e); end
    end
    if (rd1) begin
      logic [7:0] e; string t;
      e = exp1.pop_front(); t = tag1.pop_front();
      total++;
      if (q1_rd !== e) begin bad++; $display("FAIL %s u1: got %02h exp %02h", t, q1_rd, e); end
    end
  end

  task automatic cyc0(input logic v, input logic [2:0] c, input logic [15:0] d,
                      input logic [7:0] a, input logic w, input logic [7:0] wd,
                      input logic r, input logic [7:0] e, input string t);
    @(negedge clk);
    v0 = v; ch0 = c; d0 = d; a0 = a; wr0 = w; wd0 = wd; rd0 = r;
    if (r) begin exp0.push_back(e); tag0.push_back(t); end
  endtask
  task automatic rd_0(input logic [7:0] a, input logic [7:0] e, input string t);
    cyc0(0, 0, 0, a, 0, 0, 1, e, t);
  endtask
  task automatic wr_0(input logic [7:0] a, input logic [7:0] wd);
    cyc0(0, 0, 0, a, 1, wd, 0, 0, "");
  endtask
  task automatic sm_0(input logic [2:0] c, input logic [15:0] d);
    cyc0(1, c, d, 0, 0, 0, 0, 0, "");
  endtask

  task automatic cyc1(input logic v, input logic [2:0] c, input logic [15:0] d,
                      input logic [7:0] a, input logic w, input logic [7:0] wd,
                      input logic r, input logic [7:0] e, input string t);
    @(negedge clk);
    v1 = v; ch1 = c; d1 = d; a1 = a; wr1 = w; wd1 = wd; rd1 = r;
    if (r) begin exp1.push_back(e); tag1.push_back(t); end
  endtask
  task automatic rd_1(input logic [7:0] a, input logic [7:0] e, input string t);
    cyc1(0, 0, 0, a, 0, 0, 1, e, t);
  endtask
  task automatic wr_1(input logic [7:0] a, input logic [7:0] wd);
    cyc1(0, 0, 0, a, 1, wd, 0, 0, "");
  endtask
  task automatic sm_1(input logic [2:0] c, input logic [15:0] d);
    cyc1(1, c, d, 0, 0, 0, 0, 0, "");
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_0(8'h11, 8'h00, "R1"); rd_0(8'h12, 8'h00, "R1");
    rd_0(8'h13, 8'h00, "R1"); rd_0(8'h14, 8'h00, "R1");
    rd_0(8'h20, 8'h00, "R1"); rd_0(8'h22, 8'hFF, "R1"); rd_0(8'h3F, 8'hFF, "R1");
    // R2 equal to default high limit: no alarm
    sm_0(3'd0, 16'hFFFF); rd_0(8'h12, 8'h00, "R2"); rd_0(8'h11, 8'h00, "R2");
    // R7 limits of channel 2
    wr_0(8'h28, 8'h00); wr_0(8'h29, 8'h01); wr_0(8'h2A, 8'h00); wr_0(8'h2B, 8'h80);
    rd_0(8'h29, 8'h01, "R7"); rd_0(8'h2B, 8'h80, "R7"); rd_0(8'h2A, 8'h00, "R7");
    rd_0(8'h40, 8'h00, "R7");
    // R2/R6 low alarm ch2 -> bit 3
    sm_0(3'd2, 16'h00FF);
    rd_0(8'h12, 8'h08, "R6"); rd_0(8'h11, 8'h08, "R4"); rd_0(8'h11, 8'h00, "R4");
    rd_0(8'h12, 8'h08, "R4");
    // R2 strict: equal to low limit
    sm_0(3'd2, 16'h0100); rd_0(8'h12, 8'h00, "R2"); rd_0(8'h11, 8'h00, "R2");
    // R3 high alarm ch2 -> bit 2, then back in range
    sm_0(3'd2, 16'h8001); sm_0(3'd2, 16'h1000);
    rd_0(8'h12, 8'h00, "R3"); rd_0(8'h11, 8'h04, "R3"); rd_0(8'h11, 8'h00, "R3");
    // R6 upper bytes: ch5 high -> bit 4, ch7 low -> bit 1
    wr_0(8'h36, 8'h10); wr_0(8'h37, 8'h00);
    sm_0(3'd5, 16'h0020);
    rd_0(8'h14, 8'h10, "R6"); rd_0(8'h13, 8'h10, "R6"); rd_0(8'h13, 8'h00, "R4");
    rd_0(8'h11, 8'h00, "R6");
    wr_0(8'h3C, 8'h05);
    sm_0(3'd7, 16'h0003);
    rd_0(8'h14, 8'h12, "R6"); rd_0(8'h13, 8'h02, "R6");
    // R5 set wins against clearing read
    sm_0(3'd2, 16'h9000);
    cyc0(1, 3'd2, 16'h9000, 8'h11, 0, 0, 1, 8'h04, "R5");
    rd_0(8'h11, 8'h04, "R5"); rd_0(8'h11, 8'h00, "R5");
    // R8 writes to flag bytes ignored
    wr_0(8'h11, 8'hFF); wr_0(8'h12, 8'hFF); wr_0(8'h13, 8'hFF);
    rd_0(8'h11, 8'h00, "R8"); rd_0(8'h12, 8'h04, "R8"); rd_0(8'h13, 8'h00, "R8");
    cyc0(0, 0, 0, 0, 0, 0, 0, 0, "");

    // R9 reduced build
    rd_1(8'h13, 8'hFF, "R9"); rd_1(8'h14, 8'hFF, "R9");
    wr_1(8'h26, 8'h00); wr_1(8'h27, 8'h01);
    sm_1(3'd1, 16'h0200);
    rd_1(8'h12, 8'h10, "R9");
    wr_1(8'h36, 8'h55); wr_1(8'h37, 8'h00);
    rd_1(8'h36, 8'h00, "R9"); rd_1(8'h37, 8'h00, "R9");
    sm_1(3'd5, 16'h8000); sm_1(3'd4, 16'h0000);
    rd_1(8'h12, 8'h10, "R9"); rd_1(8'h11, 8'h10, "R9");
    wr_1(8'h13, 8'hAA);
    rd_1(8'h13, 8'hFF, "R9"); rd_1(8'h11, 8'h00, "R9");
    cyc1(0, 0, 0, 0, 0, 0, 0, 0, "");

    repeat (3) @(negedge clk);
    if (exp0.size() != 0 || exp1.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: got %0d left exp 0", exp0.size() + exp1.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule